// File: doc/BRIEF.md
# Direct Address Store Unit

This block executes byte stores whose target address is carried inside the instruction itself. Two encodings are handled. The wide form spans two instruction words: an opcode word that names a source register out of 32, followed by a word holding a full 16-bit absolute address. An extension byte, supplied from outside, provides the address bits above 64K. The compact form fits in a single word. It names one of the upper sixteen registers and carries a 7-bit address, which is expanded into a fixed window of the data space.

Instruction words arrive one per cycle with a valid flag. The unit drives a register file read index and takes the byte back in the same cycle. On completion it issues a one-cycle data-space write strobe, together with address and data, and reports how many words the program counter must advance.

A flush input, or a reset, abandons a wide store that is still waiting for its address word.

Top module: `dstore_unit`

## Requirements
- R1: After reset, `wr_en` is 0, `pc_step` is 0, `wr_addr` and `wr_data` are 0, and the unit waits for an opcode.
- R2: A valid word matching `1001 001s ssss 0000` (bits 15:9 = 1001001, bits 3:0 = 0000, source register s = bits 8:4) produces no write and a `pc_step` of 0 in the cycle after it is taken. The unit then waits for an address word.
- R3: The next valid word after a wide opcode is the address k. One cycle after that word is taken, `wr_en` is 1, `wr_addr` = {`ext_byte`, k}, `wr_data` = register s, and `pc_step` = 2.
- R4: While the unit waits for an address word, cycles without a valid word leave it waiting and write nothing. Any valid word taken in that state is used as the address, even if it matches an opcode pattern.
- R5: A valid word matching `1010 1xxx dddd xxxx` (bits 15:11 = 10101) is the compact form. One cycle later, `wr_en` is 1, `pc_step` is 1, and `wr_data` is register 16+d, where d = bits 7:4.
- R6: The compact address is formed as follows. Bit 7 = NOT word bit 8. Bit 6 = word bit 8. Bits 5:4 = word bits 10:9. Bits 3:0 = word bits 3:0. All address bits above bit 7 are 0, whatever `ext_byte` holds, so the address lies in 0x40..0xBF.
- R7: A flush, or a reset, while the unit waits for an address word abandons the store. No write follows, and the next valid word is decoded as an opcode. A flush in the same cycle as a valid word makes the unit ignore that word.
- R8: A valid word that matches neither form produces no write and a `pc_step` of 0, and it does not start a wait for an address.
- R9: `wr_en` and `pc_step` are high or nonzero for exactly one cycle per completed store. Compact stores in consecutive cycles give consecutive write strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drops the word in flight and any pending wide store |
| ins_valid | input | 1 | Instruction word valid |
| ins_word | input | 16 | Instruction word |
| ext_byte | input | EXT_W | Address bits above 64K for wide stores |
| rf_rd_idx | output | 5 | Register file read index |
| rf_rd_data | input | DATA_W | Register file read data, same cycle |
| wr_en | output | 1 | Data-space write strobe |
| wr_addr | output | 16+EXT_W | Data-space write address |
| wr_data | output | DATA_W | Data-space write byte |
| pc_step | output | 2 | Program counter advance in words (0, 1 or 2) |

## Verification
Wide stores are driven with the address word arriving back to back with the opcode, and again after several idle cycles. They are also driven with an address word that looks like an opcode, which shows that the wait state, not the decoder, owns that word. Compact stores use the two corner addresses 0x40 and 0xBF, a mixed bit pattern, and a saturated extension byte, which separates a correct bit map from a shifted or extended one. Flushes and resets placed during the wait, words that almost match either form, and consecutive compact stores show that a store is abandoned cleanly, that non-matching words are ignored, and that strobes neither merge nor go missing.

// File: rtl/dstore_pkg.sv
package dstore_pkg;
   localparam int WORD_W  = 16;
   localparam int REG_W   = 5;
   localparam int SADDR_W = 8;

   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_LONG  = 2'd1,
      OP_SHORT = 2'd2
   } op_kind_t;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_ADDR = 1'b1
   } seq_state_t;

   typedef struct packed {
      op_kind_t                kind;
      logic [REG_W-1:0]        src;
      logic [SADDR_W-1:0]      saddr;
   } dec_t;
endpackage

// File: rtl/dstore_shortmap.sv
module dstore_shortmap
   import dstore_pkg::*;
(
   input  logic [WORD_W-1:0]  word_i,
   output logic [SADDR_W-1:0] addr_o
);
   // 7-bit embedded address expanded into the 0x40..0xBF window
   assign addr_o = {~word_i[8], word_i[8], word_i[10:9], word_i[3:0]};
endmodule

// File: rtl/dstore_decode.sv
module dstore_decode
   import dstore_pkg::*;
#(
   parameter bit SHORT_EN = 1'b1
)(
   input  logic [WORD_W-1:0] word_i,
   output dec_t              dec_o
);
   logic is_long;
   assign is_long = (word_i[15:9] == 7'b1001001) && (word_i[3:0] == 4'b0000);

   generate
      if (SHORT_EN) begin : g_short
         logic [SADDR_W-1:0] smap;
         logic               is_short;

         dstore_shortmap u_map (
            .word_i (word_i),
            .addr_o (smap)
         );

         assign is_short = (word_i[15:11] == 5'b10101);

         always_comb begin
            dec_o.saddr = smap;
            if (is_long) begin
               dec_o.kind = OP_LONG;
               dec_o.src  = word_i[8:4];
            end else if (is_short) begin
               dec_o.kind = OP_SHORT;
               dec_o.src  = {1'b1, word_i[7:4]};
            end else begin
               dec_o.kind = OP_NONE;
               dec_o.src  = '0;
            end
         end
      end else begin : g_long_only
         always_comb begin
            dec_o.saddr = '0;
            if (is_long) begin
               dec_o.kind = OP_LONG;
               dec_o.src  = word_i[8:4];
            end else begin
               dec_o.kind = OP_NONE;
               dec_o.src  = '0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/dstore_seq.sv
module dstore_seq
   import dstore_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int EXT_W  = 8
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    flush_i,
   input  logic                    valid_i,
   input  logic [WORD_W-1:0]       word_i,
   input  dec_t                    dec_i,
   input  logic [EXT_W-1:0]        ext_i,
   input  logic [DATA_W-1:0]       rf_data_i,
   output logic [REG_W-1:0]        rf_idx_o,
   output logic                    wr_en_o,
   output logic [WORD_W+EXT_W-1:0] wr_addr_o,
   output logic [DATA_W-1:0]       wr_data_o,
   output logic [1:0]              pc_step_o
);
   localparam int OUT_AW = WORD_W + EXT_W;
   localparam int PAD_W  = OUT_AW - SADDR_W;

   seq_state_t       state;
   logic [REG_W-1:0] src_q;
   logic             take;

   assign take     = valid_i && !flush_i;
   assign rf_idx_o = (state == SEQ_ADDR) ? src_q : dec_i.src;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= SEQ_IDLE;
         src_q     <= '0;
         wr_en_o   <= 1'b0;
         wr_addr_o <= '0;
         wr_data_o <= '0;
         pc_step_o <= 2'd0;
      end else begin
         wr_en_o   <= 1'b0;
         pc_step_o <= 2'd0;
         case (state)
            SEQ_IDLE: begin
               if (take) begin
                  if (dec_i.kind == OP_LONG) begin
                     state <= SEQ_ADDR;
                     src_q <= dec_i.src;
                  end else if (dec_i.kind == OP_SHORT) begin
                     wr_en_o   <= 1'b1;
                     wr_addr_o <= {{PAD_W{1'b0}}, dec_i.saddr};
                     wr_data_o <= rf_data_i;
                     pc_step_o <= 2'd1;
                  end
               end
            end
            SEQ_ADDR: begin
               if (flush_i) begin
                  state <= SEQ_IDLE;
               end else if (valid_i) begin
                  state     <= SEQ_IDLE;
                  wr_en_o   <= 1'b1;
                  wr_addr_o <= {ext_i, word_i};
                  wr_data_o <= rf_data_i;
                  pc_step_o <= 2'd2;
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_ADDR && !valid_i && !flush_i) |=> (state == SEQ_ADDR && !wr_en_o)); // R4

   AST_FLUSH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> !wr_en_o); // R7

   AST_LONG_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_o && pc_step_o == 2'd2) |-> $past(state == SEQ_ADDR)); // R3

   AST_OPCODE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_IDLE && valid_i && dec_i.kind == OP_LONG) |=> (!wr_en_o && pc_step_o == 2'd0)); // R2
endmodule

// File: rtl/dstore_unit.sv
module dstore_unit
   import dstore_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int EXT_W    = 8,
   parameter bit SHORT_EN = 1'b1
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    flush,
   input  logic                    ins_valid,
   input  logic [15:0]             ins_word,
   input  logic [EXT_W-1:0]        ext_byte,
   output logic [4:0]              rf_rd_idx,
   input  logic [DATA_W-1:0]       rf_rd_data,
   output logic                    wr_en,
   output logic [16+EXT_W-1:0]     wr_addr,
   output logic [DATA_W-1:0]       wr_data,
   output logic [1:0]              pc_step
);
   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("dstore_unit: DATA_W must be at least 1");
      end
      if (EXT_W < 1) begin : g_bad_ext
         $error("dstore_unit: EXT_W must be at least 1");
      end
   endgenerate

   dec_t dec;

   dstore_decode #(
      .SHORT_EN (SHORT_EN)
   ) u_dec (
      .word_i (ins_word),
      .dec_o  (dec)
   );

   dstore_seq #(
      .DATA_W (DATA_W),
      .EXT_W  (EXT_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush_i   (flush),
      .valid_i   (ins_valid),
      .word_i    (ins_word),
      .dec_i     (dec),
      .ext_i     (ext_byte),
      .rf_data_i (rf_rd_data),
      .rf_idx_o  (rf_rd_idx),
      .wr_en_o   (wr_en),
      .wr_addr_o (wr_addr),
      .wr_data_o (wr_data),
      .pc_step_o (pc_step)
   );

   AST_SHORT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && pc_step == 2'd1) |-> (wr_addr >= 'h40 && wr_addr <= 'hBF)); // R6

   AST_SHORT_UPPER_REG: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && pc_step == 2'd1) |-> $past(rf_rd_idx[4])); // R5

   AST_STEP_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_step != 2'd0) |-> wr_en); // R9
endmodule

// File: tb/dstore_unit_tb.sv
module dstore_unit_tb;
   localparam int DATA_W = 8;
   localparam int EXT_W  = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              flush = 1'b0;
   logic              ins_valid = 1'b0;
   logic [15:0]       ins_word = '0;
   logic [EXT_W-1:0]  ext_byte = '0;
   logic [4:0]        rf_rd_idx;
   logic [DATA_W-1:0] rf_rd_data;
   logic              wr_en;
   logic [23:0]       wr_addr;
   logic [DATA_W-1:0] wr_data;
   logic [1:0]        pc_step;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   function automatic logic [7:0] reg_val(input logic [4:0] i);
      return 8'(i * 8'd7 + 8'h11);
   endfunction

   assign rf_rd_data = reg_val(rf_rd_idx);

   dstore_unit u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .ins_valid  (ins_valid),
      .ins_word   (ins_word),
      .ext_byte   (ext_byte),
      .rf_rd_idx  (rf_rd_idx),
      .rf_rd_data (rf_rd_data),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .pc_step    (pc_step)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic step(input logic [15:0] w, input logic v, input logic f);
      ins_word  = w;
      ins_valid = v;
      flush     = f;
      @(posedge clk);
      @(negedge clk);
      ins_valid = 1'b0;
      flush     = 1'b0;
   endtask

   function automatic logic [15:0] long_word(input logic [4:0] s);
      return {7'b1001001, s, 4'b0000};
   endfunction

   function automatic logic [15:0] short_word(input logic [3:0] d, input logic [6:0] k);
      return {5'b10101, k[5:4], k[6], d, k[3:0]};
   endfunction

   task automatic t_reset;
      chk("R1 wr_en", 32'(wr_en), 0);
      chk("R1 pc_step", 32'(pc_step), 0);
      chk("R1 wr_addr", 32'(wr_addr), 0);
      chk("R1 wr_data", 32'(wr_data), 0);
   endtask

   task automatic t_long(input logic [4:0] s, input logic [15:0] k, input logic [7:0] e);
      ext_byte = e;
      step(long_word(s), 1'b1, 1'b0);
      chk("R2 no write on opcode", 32'(wr_en), 0);
      chk("R2 pc_step on opcode", 32'(pc_step), 0);
      step(k, 1'b1, 1'b0);
      chk("R3 wr_en", 32'(wr_en), 1);
      chk("R3 wr_addr", 32'(wr_addr), 32'({e, k}));
      chk("R3 wr_data", 32'(wr_data), 32'(reg_val(s)));
      chk("R3 pc_step", 32'(pc_step), 2);
      step(16'h0000, 1'b0, 1'b0);
      chk("R9 strobe drops", 32'(wr_en), 0);
      chk("R9 pc_step drops", 32'(pc_step), 0);
   endtask

   task automatic t_long_gap;
      ext_byte = 8'h03;
      step(long_word(5'd9), 1'b1, 1'b0);
      for (int i = 0; i < 3; i++) begin
         step(16'hFFFF, 1'b0, 1'b0);
         chk("R4 idle in wait", 32'(wr_en), 0);
      end
      step(16'h9200, 1'b1, 1'b0);
      chk("R4 opcode-like address used", 32'(wr_addr), 32'h039200);
      chk("R4 write after gap", 32'(wr_en), 1);
      chk("R4 data after gap", 32'(wr_data), 32'(reg_val(5'd9)));
   endtask

   task automatic t_short(input logic [3:0] d, input logic [6:0] k, input logic [7:0] exp_a);
      ext_byte = 8'hFF;
      step(short_word(d, k), 1'b1, 1'b0);
      chk("R5 wr_en", 32'(wr_en), 1);
      chk("R5 pc_step", 32'(pc_step), 1);
      chk("R5 wr_data", 32'(wr_data), 32'(reg_val({1'b1, d})));
      chk("R6 wr_addr", 32'(wr_addr), 32'(exp_a));
   endtask

   task automatic t_flush_wait;
      step(long_word(5'd4), 1'b1, 1'b0);
      step(16'h1234, 1'b1, 1'b1);
      chk("R7 flush in wait", 32'(wr_en), 0);
      step(16'h1234, 1'b1, 1'b0);
      chk("R7 wait abandoned", 32'(wr_en), 0);
      step(short_word(4'd2, 7'h15), 1'b1, 1'b1);
      chk("R7 flushed short ignored", 32'(wr_en), 0);
   endtask

   task automatic t_reset_wait;
      step(long_word(5'd7), 1'b1, 1'b0);
      rst_n = 1'b0;
      step(16'h0000, 1'b0, 1'b0);
      rst_n = 1'b1;
      step(16'h1234, 1'b1, 1'b0);
      chk("R7 reset abandons wait", 32'(wr_en), 0);
      chk("R7 reset pc_step", 32'(pc_step), 0);
   endtask

   task automatic t_other;
      logic [15:0] ws [3] = '{16'h0000, 16'h9201, 16'hA000};
      foreach (ws[i]) begin
         step(ws[i], 1'b1, 1'b0);
         chk("R8 no write", 32'(wr_en), 0);
         chk("R8 no pc_step", 32'(pc_step), 0);
      end
      step(16'h1234, 1'b1, 1'b0);
      chk("R8 no wait started", 32'(wr_en), 0);
   endtask

   task automatic t_back_to_back;
      step(short_word(4'd1, 7'h00), 1'b1, 1'b0);
      chk("R9 first strobe", 32'(wr_en), 1);
      chk("R9 first addr", 32'(wr_addr), 32'h80);
      step(short_word(4'd3, 7'h7F), 1'b1, 1'b0);
      chk("R9 second strobe", 32'(wr_en), 1);
      chk("R9 second addr", 32'(wr_addr), 32'h7F);
      chk("R9 second data", 32'(wr_data), 32'(reg_val(5'd19)));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_long(5'd0, 16'h0000, 8'h00);
      t_long(5'd31, 16'hFFFF, 8'hA5);
      t_long(5'd17, 16'h1F2E, 8'h01);
      t_long_gap;
      t_short(4'd0, 7'h40, 8'h40);
      t_short(4'd15, 7'h3F, 8'hBF);
      t_short(4'd6, 7'h5A, 8'h5A);
      t_short(4'd9, 7'h25, 8'hA5);
      t_flush_wait;
      t_reset_wait;
      t_other;
      t_back_to_back;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule